// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block takes an address from a memory-mapped read path and decides which of four serial flash devices it belongs to. The devices sit on two buses, A and B, with two chip selects on each bus. Software splits the mapped window into four consecutive regions by programming one top-address register per device. Each region begins where the previous one ends, and the first region begins at the window base. Because of this, a device whose top equals the previous top owns zero bytes, and a single device can be given the whole window.

A configuration input selects whether the window base is added inside the block. When it is set, the top registers hold offsets from the base. When it is clear, they hold absolute addresses. A fifth register holds the start address for commands that software starts itself. It is driven straight to a port and does not take part in decoding.

Each lookup produces, one clock later, a one-hot device select, the bus and chip-select bits, and the offset inside the chosen device. An invalid flag is raised instead when the address falls outside every region.

Top module: `csdec_top`

## Requirements
- R1: After the synchronous reset, every effective top address equals the window base, so every lookup reports invalid; `out_vld` is 0 while reset is held.
- R2: An address belongs to a region when it is greater than or equal to the region start and strictly less than the region top; the address equal to a top belongs to the next non-empty region.
- R3: When several regions contain the address, the lowest-indexed one is chosen, and at most one bit of `out_sel` is set.
- R4: An address that lies in no region (below the base, or at or above the last region's end) gives `out_invalid`=1 with `out_sel`, `out_bus`, `out_cs` and `out_offset` all 0.
- R5: `out_offset` equals the address minus the start of the chosen region.
- R6: With `base_int`=1, the effective top of device i is the window base plus register i, and reset loads the registers with 0.
- R7: A single device owns the whole window when the earlier tops equal the base; zero-size regions are never chosen.
- R8: The device index is 0=A1, 1=A2, 2=B1, 3=B2. `out_sel` bit i marks device i, `out_bus` is index bit 1 (0=A, 1=B), and `out_cs` is index bit 0.
- R9: A write with `wr_idx`=4 loads `flash_cmd_addr` on the next cycle and leaves decoding unchanged. Write indices 0 to 3 load the top registers of devices 0 to 3.
- R10: A write with `wr_idx` from 5 to 7 changes neither the top registers nor `flash_cmd_addr`.
- R11: `out_vld` is `rd_valid` delayed by one cycle, and the other outputs describe the address presented in that earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_int | input | 1 | 1: top registers are offsets from the window base |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index: 0-3 device tops, 4 command address |
| wr_data | input | ADDR_W | Write data |
| rd_valid | input | 1 | Lookup request |
| rd_addr | input | ADDR_W | Absolute address to decode |
| flash_cmd_addr | output | ADDR_W | Start address for software-started commands |
| out_vld | output | 1 | Decode result valid |
| out_sel | output | 4 | One-hot device select |
| out_bus | output | 1 | Selected bus (0=A, 1=B) |
| out_cs | output | 1 | Chip select within the bus |
| out_offset | output | ADDR_W | Offset inside the selected device |
| out_invalid | output | 1 | Address outside every region |

## Verification
The assertions assume that `base_int` is changed only while reset is held, because the register reset value depends on it. They also assume that writes and lookups are driven from settled values between clock edges. The stimulus follows both rules: it switches `base_int` before pulsing reset, and it drives every input on the falling edge. The bench finishes all register writes before it issues the lookups that depend on them. It keeps its own copy of the written tops, so each expected result reflects the configuration the design actually held.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  // Four devices: two buses with two chip selects each
  localparam int N_TGT = 4;
  localparam int TGT_W = 2;
  localparam int IDX_W = 3;
  // Write index that targets the command start-address register
  localparam logic [IDX_W-1:0] WR_IDX_CMD = 3'd4;

  typedef enum logic [TGT_W-1:0] {
    TGT_A1 = 2'd0,
    TGT_A2 = 2'd1,
    TGT_B1 = 2'd2,
    TGT_B2 = 2'd3
  } tgt_e;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          base_int,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [ADDR_W-1:0]             wr_data,
  output logic [N_TGT-1:0][ADDR_W-1:0]  top_q,
  output logic [ADDR_W-1:0]             cmd_q
);

  // Empty-window reset value: offset 0 when base is added, else absolute base
  logic [ADDR_W-1:0] rst_top;
  assign rst_top = base_int ? '0 : WIN_BASE;

  for (genvar i = 0; i < N_TGT; i++) begin : g_top
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      top_q[i] <= rst_top;
      else if (hit) top_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  cmd_q <= '0;
    else if (wr_en && wr_idx == WR_IDX_CMD)   cmd_q <= wr_data;
  end

  // R9
  cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == WR_IDX_CMD) |=> (cmd_q == $past(wr_data) && $stable(top_q)));

  // R10
  ignored_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx > WR_IDX_CMD) |=> ($stable(top_q) && $stable(cmd_q)));

endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic                          base_int,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_TGT-1:0][ADDR_W-1:0]  top_q,
  output logic                          hit,
  output logic [TGT_W-1:0]              win_idx,
  output logic [ADDR_W-1:0]             offset
);

  logic [N_TGT-1:0][ADDR_W-1:0] eff_top;
  logic [N_TGT-1:0][ADDR_W-1:0] start;
  logic [N_TGT-1:0]             in_rgn;

  for (genvar i = 0; i < N_TGT; i++) begin : g_cmp
    assign eff_top[i] = base_int ? (WIN_BASE + top_q[i]) : top_q[i];
    if (i == 0) begin : g_first
      assign start[i] = WIN_BASE;
    end else begin : g_next
      assign start[i] = eff_top[i-1];
    end
    assign in_rgn[i] = (addr >= start[i]) && (addr < eff_top[i]);
  end

  // Lowest index has priority
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (in_rgn[i]) begin
        hit     = 1'b1;
        win_idx = TGT_W'(i);
      end
    end
    offset = addr - start[win_idx];
  end

endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_int,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] flash_cmd_addr,
  output logic              out_vld,
  output logic [N_TGT-1:0]  out_sel,
  output logic              out_bus,
  output logic              out_cs,
  output logic [ADDR_W-1:0] out_offset,
  output logic              out_invalid
);

  logic [N_TGT-1:0][ADDR_W-1:0] top_q;
  logic                         hit;
  logic [TGT_W-1:0]             win_idx;
  logic [ADDR_W-1:0]            offset;

  csdec_regs #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_regs (
    .clk(clk), .rst(rst), .base_int(base_int),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .top_q(top_q), .cmd_q(flash_cmd_addr)
  );

  csdec_match #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_match (
    .base_int(base_int), .addr(rd_addr), .top_q(top_q),
    .hit(hit), .win_idx(win_idx), .offset(offset)
  );

  // One-cycle registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_sel     <= '0;
      out_bus     <= 1'b0;
      out_cs      <= 1'b0;
      out_offset  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_vld <= rd_valid;
      if (rd_valid) begin
        out_invalid <= !hit;
        out_sel     <= hit ? (N_TGT'(1) << win_idx) : '0;
        out_bus     <= hit & win_idx[1];
        out_cs      <= hit & win_idx[0];
        out_offset  <= hit ? offset : '0;
      end
    end
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_sel));

  // R4
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_invalid) |-> (out_sel == '0 && out_offset == '0 && !out_bus && !out_cs));

  // R8
  sel_matches_bus_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_invalid) |-> out_sel[{out_bus, out_cs}]);

  // R11
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> out_vld);

  // R11
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !out_vld);

endmodule

// File: tb/tb_csdec_top.sv
module tb_csdec_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h2000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, base_int = 1'b0, wr_en = 1'b0, rd_valid = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [AW-1:0] wr_data = '0, rd_addr = '0;
  logic [AW-1:0] flash_cmd_addr, out_offset;
  logic          out_vld, out_bus, out_cs, out_invalid;
  logic [3:0]    out_sel;

  csdec_top #(.ADDR_W(AW), .WIN_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .base_int(base_int), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .flash_cmd_addr(flash_cmd_addr), .out_vld(out_vld), .out_sel(out_sel),
    .out_bus(out_bus), .out_cs(out_cs), .out_offset(out_offset),
    .out_invalid(out_invalid)
  );

  typedef struct {
    logic [3:0]    sel;
    logic          bus;
    logic          cs;
    logic [AW-1:0] off;
    logic          inv;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [AW-1:0] mtop [4];
  int            n_chk = 0, n_fail = 0;
  bit            finished = 0;

  task automatic check(bit ok, string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Requirement model: half-open regions, lowest index wins (R2, R3, R5, R6, R8)
  function automatic exp_t model(logic [AW-1:0] a, string tag);
    exp_t e;
    logic [AW-1:0] st, tp;
    e.sel = '0; e.bus = 0; e.cs = 0; e.off = '0; e.inv = 1; e.tag = tag;
    st = BASE;
    for (int i = 0; i < 4; i++) begin
      tp = base_int ? BASE + mtop[i] : mtop[i];
      if (e.inv && a >= st && a < tp) begin
        e.inv = 0; e.sel = 4'(1 << i); e.bus = i[1]; e.cs = i[0]; e.off = a - st;
      end
      st = tp;
    end
    return e;
  endfunction

  task automatic do_reset(logic bi);
    @(negedge clk);
    base_int = bi; rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_vld == 1'b0, "R1", "out_vld in reset", AW'(out_vld), '0);
    for (int i = 0; i < 4; i++) mtop[i] = bi ? '0 : BASE;
    rst = 1'b0;
  endtask

  task automatic wr(logic [2:0] idx, logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 3'd4) mtop[idx] = d;
  endtask

  task automatic look(logic [AW-1:0] a, string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    sbq.push_back(model(a, tag));
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // Monitor: compare each result against the scoreboard head (R11 latency)
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (sbq.size() == 0) begin
        check(0, "R11", "unexpected out_vld", AW'(out_vld), '0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(out_invalid == e.inv, e.tag, "invalid", AW'(out_invalid), AW'(e.inv));
        check(out_sel == e.sel, e.tag, "sel", AW'(out_sel), AW'(e.sel));
        check(out_bus == e.bus && out_cs == e.cs, e.tag, "bus/cs",
              AW'({out_bus, out_cs}), AW'({e.bus, e.cs}));
        check(out_offset == e.off, e.tag, "offset", out_offset, e.off);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "R11", "watchdog expired", '0, '1);
    summary();
  end

  initial begin
    // R1: empty regions after reset, absolute mode
    do_reset(1'b0);
    look(BASE, "R1");
    look(BASE + 32'h10, "R1");

    // R2/R5/R7/R8: A1 4K, A2 8K, B1 empty, B2 20K
    wr(3'd0, BASE + 32'h1000);
    wr(3'd1, BASE + 32'h3000);
    wr(3'd2, BASE + 32'h3000);
    wr(3'd3, BASE + 32'h8000);
    look(BASE, "R2");
    look(BASE + 32'hFFF, "R5");
    look(BASE + 32'h1000, "R2");
    look(BASE + 32'h2FFF, "R8");
    look(BASE + 32'h3000, "R7");
    look(BASE + 32'h7FFF, "R5");
    look(BASE + 32'h8000, "R4");
    look(BASE - 32'h1, "R4");

    // R9: command address register, decode untouched
    wr(3'd4, 32'h1234_5678);
    @(negedge clk);
    check(flash_cmd_addr == 32'h1234_5678, "R9", "cmd addr", flash_cmd_addr, 32'h1234_5678);
    look(BASE + 32'h1800, "R9");

    // R10: unused indices ignored
    wr(3'd7, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    @(negedge clk);
    check(flash_cmd_addr == 32'h1234_5678, "R10", "cmd addr kept", flash_cmd_addr, 32'h1234_5678);
    look(BASE + 32'h10, "R10");
    look(BASE + 32'h7000, "R10");

    // R3: overlapping regions, lowest index wins
    wr(3'd0, BASE + 32'h4000);
    wr(3'd1, BASE + 32'h2000);
    wr(3'd2, BASE + 32'h6000);
    look(BASE + 32'h3000, "R3");
    look(BASE + 32'h5000, "R3");
    look(BASE + 32'h6000, "R3");

    // R7: whole window to B2
    wr(3'd0, BASE);
    wr(3'd1, BASE);
    wr(3'd2, BASE);
    wr(3'd3, BASE + 32'h1_0000);
    look(BASE, "R7");
    look(BASE + 32'hFFFF, "R7");
    look(BASE + 32'h1_0000, "R4");

    // R6: base added internally
    do_reset(1'b1);
    look(BASE, "R1");
    wr(3'd0, 32'h100);
    wr(3'd1, 32'h200);
    wr(3'd2, 32'h300);
    wr(3'd3, 32'h400);
    look(BASE + 32'h150, "R6");
    look(BASE + 32'h3FF, "R6");
    look(BASE + 32'h400, "R6");
    look(BASE + 32'hFF, "R6");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R11", "results outstanding", AW'(sbq.size()), '0);
    summary();
  end
endmodule